// File: doc/BRIEF.md
# Ordered Host-to-Device Block Read Engine

This engine copies one contiguous block from host memory into a local device buffer. Software, or a controlling state machine, supplies a host byte address and a byte length and pulses `start`. The engine then cuts the block into memory-read requests and presents them one at a time on a valid/ready request port.

Every request carries the same tag. The engine then waits until all completion bytes for that request have arrived before it presents the next one. Completion beats carry a tag, a success flag, a byte count and a data word. Each good beat is forwarded at once to a buffer write port at the block-relative byte offset.

When the last byte of the block has arrived, the engine raises a one-cycle interrupt and sets a done flag. A completion with a failed status or a foreign tag ends the job. So does a completion that does not arrive within a bounded number of cycles. In those cases the engine raises the same interrupt and sets an error flag instead.

Top module: `rd_dma_engine`

## Requirements
- R1: Every request length is nonzero and at most `MAX_RD` bytes.
- R2: No request spans a 4096-byte host address page: request address modulo 4096, plus the request length, is at most 4096.
- R3: Requests cover the block in ascending order with no gap. The first request starts at the job address, each later request starts where the previous one ended, and the lengths sum to the job length. While `req_valid` is high and `req_ready` is low, the request address and length hold.
- R4: Only one request is outstanding at a time. `req_valid` stays low from the accepting handshake until the completion bytes for that request sum to its length. Every request carries tag `TAG_VAL`.
- R5: A completion beat with `cpl_ok`=1 and `cpl_tag`=`TAG_VAL` that arrives while a request is outstanding asserts `buf_we` in the same cycle. At the same time, `buf_addr` equals the number of block bytes received before that beat, and `buf_data`/`buf_bytes` equal `cpl_data`/`cpl_bytes`.
- R6: On the clock edge that takes the final byte of the block, the engine returns idle (`busy`=0). It pulses `irq` high for exactly one cycle and sets `done_o`=1, with `err_o`=0.
- R7: A completion beat with `cpl_ok`=0, or with a tag other than `TAG_VAL`, is not written (`buf_we`=0). The engine aborts to idle with a one-cycle `irq` pulse, `err_o`=1 and `done_o`=0, and issues no further request.
- R8: Once a request has been accepted, if `TIMEOUT` consecutive clock edges pass with no completion beat, the job aborts on the `TIMEOUT`-th edge exactly as in R7. A beat present on that edge is taken instead, and each beat restarts the count.
- R9: `start` with a zero `job_len` is ignored, and so is `start` while `busy`=1. Neither starts a request, changes the address sequence or produces `irq`.
- R10: After reset, `busy`, `req_valid`, `irq`, `done_o`, `err_o` and `buf_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| job_addr | input | AW | Host byte address of the block |
| job_len | input | LW | Block length in bytes |
| busy | output | 1 | Job in progress |
| done_o | output | 1 | Last job finished successfully |
| err_o | output | 1 | Last job aborted |
| irq | output | 1 | One-cycle end-of-job pulse |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request taken |
| req_addr | output | AW | Request host address |
| req_len | output | RLW | Request length in bytes |
| req_tag | output | TAG_W | Request tag, always TAG_VAL |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_ok | input | 1 | Completion status is successful |
| cpl_bytes | input | BCW | Valid bytes in this beat |
| cpl_data | input | DW | Completion data |
| buf_we | output | 1 | Local buffer write strobe |
| buf_addr | output | LW | Block-relative byte offset |
| buf_data | output | DW | Buffer write data |
| buf_bytes | output | BCW | Valid bytes in the write |

## Verification
The assertions assume the following about the completion side:
- beats appear only while a request is outstanding;
- each beat's `cpl_bytes` lies between 1 and the beat width;
- no request receives more bytes in total than it asked for.

The bench's host model respects all three assumptions. It replies only after a handshake, and it sizes each beat as the smaller of four bytes and the bytes still owed. It withholds or corrupts beats only in the timeout and abort tests.

// File: rtl/rd_dma_engine.sv
module rd_dma_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32,
  parameter int MAX_RD = 128,
  parameter int TAG_W = 8,
  parameter int TAG_VAL = 5,
  parameter int TIMEOUT = 1024,
  localparam int BB = DW / 8,
  localparam int BCW = $clog2(BB) + 1,
  localparam int RLW = $clog2(MAX_RD) + 1,
  localparam int TMW = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    job_addr,
  input  logic [LW-1:0]    job_len,
  output logic             busy,
  output logic             done_o,
  output logic             err_o,
  output logic             irq,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [RLW-1:0]   req_len,
  output logic [TAG_W-1:0] req_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic             cpl_ok,
  input  logic [BCW-1:0]   cpl_bytes,
  input  logic [DW-1:0]    cpl_data,
  output logic             buf_we,
  output logic [LW-1:0]    buf_addr,
  output logic [DW-1:0]    buf_data,
  output logic [BCW-1:0]   buf_bytes
);
  localparam int PAGE = 4096;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t            st;
  logic [AW-1:0]  cur_addr;
  logic [LW-1:0]  remain, off, pend, got;
  logic [TMW-1:0] timer;
  logic           done_q, err_q, irq_q;

  logic [LW-1:0]  to_bnd, cap, nxt_len, got_n;
  logic           beat, good, bad, req_last, blk_last, expired;

  assign to_bnd   = LW'(PAGE) - LW'(cur_addr[11:0]);
  assign cap      = (remain < LW'(MAX_RD)) ? remain : LW'(MAX_RD);
  assign nxt_len  = (to_bnd < cap) ? to_bnd : cap;

  assign beat     = (st == S_WAIT) && cpl_valid;
  assign good     = beat && cpl_ok && (cpl_tag == TAG_W'(TAG_VAL));
  assign bad      = beat && !good;
  assign got_n    = got + LW'(cpl_bytes);
  assign req_last = got_n >= pend;
  assign blk_last = remain == pend;
  assign expired  = (st == S_WAIT) && !cpl_valid && (timer == TMW'(TIMEOUT - 1));

  assign busy      = st != S_IDLE;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign irq       = irq_q;
  assign req_valid = st == S_REQ;
  assign req_addr  = cur_addr;
  assign req_len   = RLW'(nxt_len);
  assign req_tag   = TAG_W'(TAG_VAL);
  assign buf_we    = good;
  assign buf_addr  = off;
  assign buf_data  = cpl_data;
  assign buf_bytes = cpl_bytes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      off      <= '0;
      pend     <= '0;
      got      <= '0;
      timer    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start && job_len != '0) begin
          cur_addr <= job_addr;
          remain   <= job_len;
          off      <= '0;
          done_q   <= 1'b0;
          err_q    <= 1'b0;
          st       <= S_REQ;
        end
        S_REQ: if (req_ready) begin
          pend  <= nxt_len;
          got   <= '0;
          timer <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (good) begin
            off   <= off + LW'(cpl_bytes);
            got   <= got_n;
            timer <= '0;
            if (req_last) begin
              cur_addr <= cur_addr + AW'(pend);
              remain   <= remain - pend;
              if (blk_last) begin
                done_q <= 1'b1;
                irq_q  <= 1'b1;
                st     <= S_IDLE;
              end else begin
                st <= S_REQ;
              end
            end
          end else if (bad || expired) begin
            err_q <= 1'b1;
            irq_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rd_dma_engine_chk #(
  parameter int AW = 32,
  parameter int RLW = 8,
  parameter int TAG_W = 8,
  parameter int MAX_RD = 128,
  parameter int TAG_VAL = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done_o,
  input logic             err_o,
  input logic             irq,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic [RLW-1:0]   req_len,
  input logic [TAG_W-1:0] req_tag,
  input logic             cpl_valid,
  input logic [TAG_W-1:0] cpl_tag,
  input logic             cpl_ok,
  input logic             buf_we
);
  p_len_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (32'(req_len) <= MAX_RD));

  p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_addr[11:0]) + 32'(req_len) <= 4096));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  p_one_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  p_tag_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_tag == TAG_W'(TAG_VAL));

  p_write_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> cpl_valid && cpl_ok && (cpl_tag == TAG_W'(TAG_VAL)) && busy);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && (done_o != err_o));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !buf_we);
endmodule

bind rd_dma_engine rd_dma_engine_chk #(
  .AW(AW), .RLW(RLW), .TAG_W(TAG_W), .MAX_RD(MAX_RD), .TAG_VAL(TAG_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_o(done_o), .err_o(err_o),
  .irq(irq), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag),
  .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_ok(cpl_ok), .buf_we(buf_we)
);

// File: tb/sim_rd_dma_engine.sv
module sim_rd_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 16, DW = 32, MAX_RD = 128, TAG_W = 8;
  localparam int TAG_VAL = 5, TIMEOUT = 16;
  localparam int BCW = 3, RLW = 8;
  localparam int NJ = 5;
  localparam int J_ADDR [NJ] = '{32'h1000, 32'h1FC0, 32'h0010, 32'h2FF8, 32'h3004};
  localparam int J_LEN  [NJ] = '{256, 200, 40, 16, 130};
  localparam int J_NREQ [NJ] = '{2, 3, 1, 2, 2};

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] job_addr = '0;
  logic [LW-1:0] job_len = '0;
  logic busy, done_o, err_o, irq, req_valid;
  logic req_ready = 0;
  logic [AW-1:0] req_addr;
  logic [RLW-1:0] req_len;
  logic [TAG_W-1:0] req_tag;
  logic cpl_valid = 0, cpl_ok = 1;
  logic [TAG_W-1:0] cpl_tag = TAG_W'(TAG_VAL);
  logic [BCW-1:0] cpl_bytes = '0;
  logic [DW-1:0] cpl_data = '0;
  logic buf_we;
  logic [LW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic [BCW-1:0] buf_bytes;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_dma_engine #(.AW(AW), .LW(LW), .DW(DW), .MAX_RD(MAX_RD), .TAG_W(TAG_W),
                  .TAG_VAL(TAG_VAL), .TIMEOUT(TIMEOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .job_addr(job_addr), .job_len(job_len),
    .busy(busy), .done_o(done_o), .err_o(err_o), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_ok(cpl_ok), .cpl_bytes(cpl_bytes), .cpl_data(cpl_data), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_bytes(buf_bytes));

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic kick(input int a, input int l);
    job_addr = AW'(a); job_len = LW'(l); start = 1;
    step();
    start = 0;
  endtask

  task automatic accept_one(output int len);
    int g = 0;
    while (!req_valid && g < 100) begin step(); g++; end
    chk(req_valid == 1, "R4 request offered", req_valid, 1);
    len = int'(req_len);
    req_ready = 1;
    step();
    req_ready = 0;
  endtask

  task automatic run_job(input int a, input int l, input int exp_n, input bit poke);
    int nreq = 0, off = 0, pend = 0, exp_addr = a, guard = 0, nb;
    bit got_irq = 0;
    kick(a, l);
    while (!got_irq && guard < 5000) begin
      cpl_valid = 0; req_ready = 0; start = 0;
      if (irq) got_irq = 1;
      else if (pend == 0) begin
        if (req_valid) begin
          chk(req_addr == AW'(exp_addr), "R3 request address", req_addr, exp_addr);
          chk(req_len != 0 && int'(req_len) <= MAX_RD, "R1 request length", req_len, MAX_RD);
          chk((int'(req_addr) % 4096) + int'(req_len) <= 4096, "R2 page crossing",
              (int'(req_addr) % 4096) + int'(req_len), 4096);
          chk(req_tag == TAG_W'(TAG_VAL), "R4 request tag", req_tag, TAG_VAL);
          req_ready = 1; pend = int'(req_len); nreq++; exp_addr += int'(req_len);
        end
      end else begin
        nb = pend > 4 ? 4 : pend;
        cpl_valid = 1; cpl_ok = 1; cpl_tag = TAG_W'(TAG_VAL);
        cpl_bytes = BCW'(nb); cpl_data = 32'(off) ^ 32'hC0DE0000;
        if (poke && nreq == 1 && off == 0) begin
          job_addr = 32'h5000; job_len = 8; start = 1;
        end
        #1;
        chk(buf_we == 1, "R5 write strobe", buf_we, 1);
        chk(int'(buf_addr) == off, "R5 write offset", buf_addr, off);
        chk(buf_data == (32'(off) ^ 32'hC0DE0000) && int'(buf_bytes) == nb, "R5 write data",
            buf_data, 32'(off) ^ 32'hC0DE0000);
        chk(req_valid == 0, "R4 single outstanding", req_valid, 0);
        off += nb; pend -= nb;
      end
      step(); guard++;
    end
    cpl_valid = 0; start = 0;
    chk(got_irq, "R6 done interrupt", got_irq, 1);
    chk(nreq == exp_n, "R3 request count", nreq, exp_n);
    chk(off == l, "R3 bytes moved", off, l);
    chk(done_o == 1 && err_o == 0 && busy == 0, "R6 done flags", {done_o, err_o, busy}, 3'b100);
    step();
    chk(irq == 0, "R6 irq one cycle", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, n;
    repeat (3) step();
    rst_n = 1;
    step();
    // R10 reset state
    chk({busy, req_valid, irq, done_o, err_o, buf_we} == 6'b0, "R10 reset outputs",
        {busy, req_valid, irq, done_o, err_o, buf_we}, 0);

    for (int i = 0; i < NJ; i++) run_job(J_ADDR[i], J_LEN[i], J_NREQ[i], 0);

    // R9 start while busy ignored
    run_job(32'h1000, 256, 2, 1);

    // R9 zero-length start ignored
    kick(32'h700, 0);
    chk(busy == 0 && req_valid == 0, "R9 zero length ignored", busy, 0);
    step();
    chk(irq == 0 && req_valid == 0, "R9 no irq on zero length", irq, 0);

    // R7 failed status
    kick(32'h400, 64);
    accept_one(len);
    cpl_valid = 1; cpl_ok = 0; cpl_bytes = 4; cpl_data = 32'h1;
    #1 chk(buf_we == 0, "R7 bad status not written", buf_we, 0);
    step();
    cpl_valid = 0; cpl_ok = 1;
    chk(irq == 1 && err_o == 1 && done_o == 0 && busy == 0, "R7 bad status abort",
        {irq, err_o, done_o, busy}, 4'b1100);
    step();
    chk(req_valid == 0 && irq == 0, "R7 no retry after abort", req_valid, 0);

    // R7 foreign tag
    kick(32'h800, 32);
    accept_one(len);
    cpl_valid = 1; cpl_tag = 3; cpl_bytes = 4;
    #1 chk(buf_we == 0, "R7 wrong tag not written", buf_we, 0);
    step();
    cpl_valid = 0; cpl_tag = TAG_W'(TAG_VAL);
    chk(irq == 1 && err_o == 1 && busy == 0, "R7 wrong tag abort", {irq, err_o, busy}, 3'b110);

    // R8 timeout
    kick(32'h100, 16);
    accept_one(len);
    n = 0;
    while (n < 3 * TIMEOUT) begin
      step(); n++;
      if (irq) break;
    end
    chk(n == TIMEOUT, "R8 timeout edge count", n, TIMEOUT);
    chk(err_o == 1 && done_o == 0 && busy == 0, "R8 timeout flags", {err_o, done_o, busy}, 3'b100);

    // R8 beat on the last allowed edge is taken
    kick(32'h200, 8);
    accept_one(len);
    for (int k = 1; k < TIMEOUT; k++) begin
      step();
      if (irq) chk(0, "R8 premature abort", k, TIMEOUT);
    end
    cpl_valid = 1; cpl_bytes = 4; cpl_data = 32'h11;
    step();
    cpl_valid = 0;
    chk(irq == 0 && busy == 1 && err_o == 0, "R8 late beat accepted", {irq, busy, err_o}, 3'b010);
    cpl_valid = 1; cpl_bytes = 4; cpl_data = 32'h22;
    #1 chk(int'(buf_addr) == 4, "R5 offset after late beat", buf_addr, 4);
    step();
    cpl_valid = 0;
    chk(irq == 1 && done_o == 1 && err_o == 0, "R6 done after late beat",
        {irq, done_o, err_o}, 3'b110);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule